// File: doc/BRIEF.md
# Lockable Set-Associative Data Cache

This block sits between a processor load/store port and a single 32-bit memory bus master and holds recently read data in a four-way set-associative array. Every request carries three attribute bits. The first says whether the access may use the cache at all. The second selects write-through or write-back for that one write. The third asks that the touched line be pinned. Lines are allocated only when a cacheable read misses. A cacheable write that misses goes straight to memory and does not allocate a line. A write that hits updates the line. Under write-through it also goes to the bus. Under write-back it only marks the line modified, and the line is copied back when it is later replaced.

The processor side uses a simple request/complete protocol. The requester raises `req_valid_i` with stable attributes, address and data, and holds it until `done_o` pulses for one cycle. It drops `req_valid_i` on that cycle or presents the next request. The bus side moves one 32-bit word per handshake. Line traffic is a run of word beats in ascending address order. The number of sets and the line length are parameters, so a simulation build can use a very small array.

Top module: `dc_top`

## Requirements
- R1: After reset every line is invalid, unmodified and unpinned, `done_o` and `mem_req_o` are low, and the first cacheable read of any address misses.
- R2: A cacheable read that hits completes with no bus beat and returns the newest value written to that address through the cache.
- R3: A cacheable read miss with a usable victim reads the whole line as LINE_WORDS read beats at ascending word addresses from the line base, then completes with the requested word.
- R4: A cacheable write miss performs exactly one bus write of that word and allocates nothing, so a later read of the same line misses.
- R5: A write-back write hit updates the line with no bus beat and marks it modified. When a modified line is replaced, all LINE_WORDS words are written to memory before the new line's first read beat.
- R6: A write-through write hit updates the line and performs exactly one bus write of that word.
- R7: Victim choice takes the lowest-numbered invalid unpinned way first. Otherwise it takes the least recently used unpinned way, where hits of any kind and fills count as uses.
- R8: A cacheable access with the pin attribute that hits or fills a line pins that line. A pinned line is never replaced, and only reset clears pins.
- R9: When all four ways of the set are pinned, a read miss performs one bus read and allocates nothing.
- R10: An uncacheable access performs exactly one bus beat and neither reads nor changes the arrays. An uncacheable read returns memory contents even when a modified cached copy exists.
- R11: While `mem_req_o` is high and `mem_ack_i` is low, the request, address, direction and write data stay unchanged into the next cycle.
- R12: `done_o` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present; held until done_o |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address, word aligned |
| req_wdata_i | input | 32 | Write data |
| req_cacheable_i | input | 1 | 1 = may use cache, 0 = bypass |
| req_wt_i | input | 1 | For writes: 1 = write-through, 0 = write-back |
| req_lock_i | input | 1 | Pin the line touched by this access |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read data, valid while done_o is high |
| mem_req_o | output | 1 | Bus beat request |
| mem_we_o | output | 1 | Bus beat direction, 1 = write |
| mem_addr_o | output | ADDR_W | Bus word address |
| mem_wdata_o | output | 32 | Bus write data |
| mem_ack_i | input | 1 | Beat accepted this cycle |
| mem_rdata_i | input | 32 | Bus read data, valid with mem_ack_i |

## Verification
The cache is exercised with repeated reads of one line, which separate a hit from a fill. Write-back and write-through writes to resident lines are set against write misses to absent lines, which exposes any allocation on write. A set is filled past capacity after one way has been refreshed, so the victim order shows true least-recently-used tracking rather than fill order. Pinned sets show that pins survive pressure and that a fully pinned set falls back to a plain bus read. Uncacheable reads of a line holding modified data show the bypass, because they return the stale memory value. The bus acknowledges only every other cycle, so each beat has to be held across a wait.

// File: rtl/dc_pkg.sv
package dc_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_WB, S_FILL, S_BUS, S_RESP
  } dc_state_e;
endpackage

// File: rtl/dc_lru.sv
module dc_lru
  import dc_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int SET_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] set_i,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAYS-1:0]  lock_i,
  output logic [WAY_W-1:0] victim_o,
  output logic             victim_ok_o
);
  // age 0 = most recent; ages in a set are always a permutation
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          age_q[set_i][w] <= '0;
        else if (age_q[set_i][w] < age_q[set_i][touch_way_i])
          age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    logic             found;
    logic             have;
    logic [WAY_W-1:0] best;
    found    = 1'b0;
    have     = 1'b0;
    best     = '0;
    victim_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !valid_i[w] && !lock_i[w]) begin
        victim_o = WAY_W'(w);
        found    = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (!lock_i[w] && (!have || age_q[set_i][w] > best)) begin
          victim_o = WAY_W'(w);
          best     = age_q[set_i][w];
          have     = 1'b1;
        end
      end
    end
    victim_ok_o = found | have;
  end

  AST_VICTIM_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_ok_o |-> !lock_i[victim_o]); // R8

  AST_TOUCH_MRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> (age_q[$past(set_i)][$past(touch_way_i)] == '0)); // R7
endmodule

// File: rtl/dc_store.sv
module dc_store
  import dc_pkg::*;
#(
  parameter int SETS       = 4,
  parameter int LINE_WORDS = 4,
  parameter int SET_W      = $clog2(SETS),
  parameter int OFF_W      = $clog2(LINE_WORDS),
  parameter int TAG_W      = 26
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [SET_W-1:0]           set_i,
  input  logic [OFF_W-1:0]           off_i,
  output logic [WAYS-1:0]            valid_o,
  output logic [WAYS-1:0]            dirty_o,
  output logic [WAYS-1:0]            lock_o,
  output logic [WAYS-1:0][TAG_W-1:0] tag_o,
  output logic [WAYS-1:0][31:0]      word_o,
  input  logic                       data_we_i,
  input  logic [WAY_W-1:0]           data_way_i,
  input  logic [OFF_W-1:0]           data_off_i,
  input  logic [31:0]                data_i,
  input  logic                       meta_we_i,
  input  logic [WAY_W-1:0]           meta_way_i,
  input  logic                       meta_valid_i,
  input  logic                       meta_dirty_i,
  input  logic                       meta_lock_i,
  input  logic [TAG_W-1:0]           meta_tag_i
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [WAYS-1:0]  lock_q  [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [31:0]      data_q  [SETS][WAYS][LINE_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        lock_q[s]  <= '0;
        for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
      end
    end else if (meta_we_i) begin
      valid_q[set_i][meta_way_i] <= meta_valid_i;
      dirty_q[set_i][meta_way_i] <= meta_dirty_i;
      lock_q[set_i][meta_way_i]  <= meta_lock_i;
      tag_q[set_i][meta_way_i]   <= meta_tag_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (data_we_i) data_q[set_i][data_way_i][data_off_i] <= data_i;
  end

  always_comb begin
    valid_o = valid_q[set_i];
    dirty_o = dirty_q[set_i];
    lock_o  = lock_q[set_i];
    for (int w = 0; w < WAYS; w++) begin
      tag_o[w]  = tag_q[set_i][w];
      word_o[w] = data_q[set_i][w][off_i];
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meta_we_i && lock_o[meta_way_i]) |-> (meta_lock_i || !meta_valid_i)); // R8
endmodule

// File: rtl/dc_top.sv
module dc_top
  import dc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 4,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  input  logic              req_cacheable_i,
  input  logic              req_wt_i,
  input  logic              req_lock_i,
  output logic              done_o,
  output logic [31:0]       rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i
);
  localparam int SET_W = $clog2(SETS);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int TAG_W = ADDR_W - SET_W - OFF_W - 2;

  dc_state_e         state_q;
  logic [ADDR_W-1:0] q_addr;
  logic [31:0]       q_wdata;
  logic              q_we, q_cach, q_wt, q_lock;
  logic [OFF_W-1:0]  beat_q;
  logic [WAY_W-1:0]  vic_q;
  logic [31:0]       rdata_q;

  logic [OFF_W-1:0] q_off;
  logic [SET_W-1:0] q_set;
  logic [TAG_W-1:0] q_tag;
  assign q_off = q_addr[OFF_W+1:2];
  assign q_set = q_addr[OFF_W+2 +: SET_W];
  assign q_tag = q_addr[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0]            valid_w, dirty_w, lock_w, hit_vec;
  logic [WAYS-1:0][TAG_W-1:0] tag_w;
  logic [WAYS-1:0][31:0]      word_w;
  logic [OFF_W-1:0]           rd_off;
  logic                       data_we, meta_we, meta_valid, meta_dirty, meta_lock;
  logic [WAY_W-1:0]           data_way, meta_way, hit_way, victim;
  logic [OFF_W-1:0]           data_off;
  logic [31:0]                data_in;
  logic [TAG_W-1:0]           meta_tag;
  logic                       touch, victim_ok, hit, last_beat;
  logic [WAY_W-1:0]           touch_way;

  assign rd_off    = (state_q == S_WB) ? beat_q : q_off;
  assign last_beat = (beat_q == OFF_W'(LINE_WORDS - 1));

  dc_store #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .SET_W(SET_W), .OFF_W(OFF_W),
             .TAG_W(TAG_W)) u_store (
    .clk_i, .rst_ni, .set_i(q_set), .off_i(rd_off),
    .valid_o(valid_w), .dirty_o(dirty_w), .lock_o(lock_w), .tag_o(tag_w), .word_o(word_w),
    .data_we_i(data_we), .data_way_i(data_way), .data_off_i(data_off), .data_i(data_in),
    .meta_we_i(meta_we), .meta_way_i(meta_way), .meta_valid_i(meta_valid),
    .meta_dirty_i(meta_dirty), .meta_lock_i(meta_lock), .meta_tag_i(meta_tag)
  );

  dc_lru #(.SETS(SETS), .SET_W(SET_W)) u_lru (
    .clk_i, .rst_ni, .set_i(q_set), .touch_i(touch), .touch_way_i(touch_way),
    .valid_i(valid_w), .lock_i(lock_w), .victim_o(victim), .victim_ok_o(victim_ok)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_w[w] && (tag_w[w] == q_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) if (hit_vec[w]) hit_way = WAY_W'(w);
  end
  assign hit = |hit_vec;

  always_comb begin
    data_we = 1'b0; data_way = hit_way; data_off = q_off; data_in = q_wdata;
    meta_we = 1'b0; meta_way = hit_way; meta_valid = 1'b1;
    meta_dirty = dirty_w[hit_way]; meta_lock = lock_w[hit_way]; meta_tag = q_tag;
    touch = 1'b0; touch_way = hit_way;
    mem_req_o = 1'b0; mem_we_o = 1'b0; mem_addr_o = '0; mem_wdata_o = '0;
    unique case (state_q)
      S_LOOK: if (q_cach && hit) begin
        touch   = 1'b1;
        data_we = q_we;
        if (q_lock || (q_we && !q_wt)) begin
          meta_we    = 1'b1;
          meta_dirty = dirty_w[hit_way] | (q_we & ~q_wt);
          meta_lock  = lock_w[hit_way] | q_lock;
        end
      end
      S_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {tag_w[vic_q], q_set, beat_q, 2'b00};
        mem_wdata_o = word_w[vic_q];
        if (mem_ack_i && last_beat) begin
          meta_we = 1'b1; meta_way = vic_q; meta_valid = 1'b0;
          meta_dirty = 1'b0; meta_lock = 1'b0; meta_tag = tag_w[vic_q];
        end
      end
      S_FILL: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {q_tag, q_set, beat_q, 2'b00};
        if (mem_ack_i) begin
          data_we = 1'b1; data_way = vic_q; data_off = beat_q; data_in = mem_rdata_i;
          if (last_beat) begin
            meta_we = 1'b1; meta_way = vic_q; meta_dirty = 1'b0; meta_lock = q_lock;
            touch = 1'b1; touch_way = vic_q;
          end
        end
      end
      S_BUS: begin
        mem_req_o   = 1'b1;
        mem_we_o    = q_we;
        mem_addr_o  = {q_addr[ADDR_W-1:2], 2'b00};
        mem_wdata_o = q_wdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      q_addr <= '0; q_wdata <= '0;
      q_we <= 1'b0; q_cach <= 1'b0; q_wt <= 1'b0; q_lock <= 1'b0;
      beat_q <= '0; vic_q <= '0; rdata_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          q_addr <= req_addr_i; q_wdata <= req_wdata_i; q_we <= req_we_i;
          q_cach <= req_cacheable_i; q_wt <= req_wt_i; q_lock <= req_lock_i;
          state_q <= S_LOOK;
        end
        S_LOOK: begin
          beat_q <= '0;
          if (!q_cach) state_q <= S_BUS;
          else if (hit) begin
            if (!q_we) rdata_q <= word_w[hit_way];
            state_q <= (q_we && q_wt) ? S_BUS : S_RESP;
          end else if (q_we || !victim_ok) state_q <= S_BUS;
          else begin
            vic_q   <= victim;
            state_q <= (valid_w[victim] && dirty_w[victim]) ? S_WB : S_FILL;
          end
        end
        S_WB: if (mem_ack_i) begin
          beat_q <= last_beat ? '0 : beat_q + 1'b1;
          if (last_beat) state_q <= S_FILL;
        end
        S_FILL: if (mem_ack_i) begin
          if (beat_q == q_off) rdata_q <= mem_rdata_i;
          beat_q <= beat_q + 1'b1;
          if (last_beat) state_q <= S_RESP;
        end
        S_BUS: if (mem_ack_i) begin
          if (!q_we) rdata_q <= mem_rdata_i;
          state_q <= S_RESP;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign done_o  = (state_q == S_RESP);
  assign rdata_o = rdata_q;

  AST_HIT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_LOOK) |-> $onehot0(hit_vec)); // R2
  AST_FILL_NOT_PINNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FILL) |-> !lock_w[vic_q]); // R8
  AST_FILL_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FILL) |-> !(valid_w[vic_q] && dirty_w[vic_q])); // R5
  AST_NC_NO_ARRAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we || meta_we || touch) |-> q_cach); // R10
  AST_BUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_we_o) && $stable(mem_wdata_o))); // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12
endmodule

// File: tb/tb_dc_top.sv
module tb_dc_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int NW = 4;
  localparam int MEMW = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_we = 0, req_c = 0, req_wt = 0, req_lk = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic done, mem_req, mem_we, mem_ack;
  logic [31:0] rdata, mem_addr, mem_wdata, mem_rdata;
  logic ack_gate = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dc_top #(.ADDR_W(32), .SETS(NS), .LINE_WORDS(NW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_cacheable_i(req_c),
    .req_wt_i(req_wt), .req_lock_i(req_lk), .done_o(done), .rdata_o(rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  // bus-side memory, acknowledges every other cycle
  logic [31:0] bmem [MEMW];
  assign mem_ack   = mem_req & ack_gate;
  assign mem_rdata = bmem[mem_addr[9:2]];
  always @(posedge clk) begin
    ack_gate <= ~ack_gate;
    if (mem_req && mem_ack && mem_we) bmem[mem_addr[9:2]] <= mem_wdata;
  end

  int n_chk = 0, n_fail = 0;
  int rd_beats = 0, wr_beats = 0;
  int rd_addr_q[$];
  logic prev_wait = 0, prev_done = 0, prev_we = 0;
  logic [31:0] prev_addr = 0, prev_wd = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // per-clock bus and completion monitor
  always @(negedge clk) if (rst_n) begin
    if (prev_wait)
      chk(mem_req && mem_addr == prev_addr && mem_we == prev_we && mem_wdata == prev_wd,
          "R11", "beat held during wait", mem_addr, prev_addr);
    if (prev_done) chk(!done, "R12", "done width", done, 0);
    if (mem_req && mem_ack) begin
      if (mem_we) wr_beats++;
      else begin
        rd_beats++;
        rd_addr_q.push_back(int'(mem_addr));
      end
    end
    prev_wait = mem_req && !mem_ack;
    prev_addr = mem_addr; prev_we = mem_we; prev_wd = mem_wdata;
    prev_done = done;
  end

  // reference model
  logic [31:0] mmem [MEMW];
  bit          m_v [NS][4], m_d [NS][4], m_l [NS][4];
  int          m_tag [NS][4];
  longint      m_ts [NS][4];
  logic [31:0] m_dat [NS][4][NW];
  longint      tick = 0;

  function automatic int adr(int t, int s, int o);
    return t * 64 + s * 16 + o * 4;
  endfunction

  task automatic model(input bit we, input int a, input logic [31:0] wd, input bit c,
                       input bit wt, input bit lk, output int er, output int ew,
                       output logic [31:0] ed, output bit fill);
    int o, s, t, wi, h, v;
    o = (a >> 2) & 3; s = (a >> 4) & 3; t = a >> 6; wi = a >> 2;
    er = 0; ew = 0; ed = 0; fill = 0; h = -1; v = -1;
    if (!c) begin
      if (we) begin mmem[wi] = wd; ew = 1; end
      else begin ed = mmem[wi]; er = 1; end
      return;
    end
    for (int w = 0; w < 4; w++) if (m_v[s][w] && m_tag[s][w] == t) h = w;
    if (h >= 0) begin
      m_ts[s][h] = ++tick;
      if (lk) m_l[s][h] = 1;
      if (we) begin
        m_dat[s][h][o] = wd;
        if (wt) begin mmem[wi] = wd; ew = 1; end else m_d[s][h] = 1;
      end else ed = m_dat[s][h][o];
    end else if (we) begin
      mmem[wi] = wd; ew = 1;
    end else begin
      for (int w = 3; w >= 0; w--) if (!m_v[s][w] && !m_l[s][w]) v = w;
      if (v < 0)
        for (int w = 0; w < 4; w++)
          if (!m_l[s][w] && (v < 0 || m_ts[s][w] < m_ts[s][v])) v = w;
      if (v < 0) begin
        er = 1; ed = mmem[wi];
      end else begin
        if (m_v[s][v] && m_d[s][v]) begin
          for (int k = 0; k < NW; k++) mmem[adr(m_tag[s][v], s, k) >> 2] = m_dat[s][v][k];
          ew = NW;
        end
        for (int k = 0; k < NW; k++) m_dat[s][v][k] = mmem[adr(t, s, k) >> 2];
        m_v[s][v] = 1; m_d[s][v] = 0; m_l[s][v] = lk; m_tag[s][v] = t;
        m_ts[s][v] = ++tick;
        er = NW; fill = 1; ed = m_dat[s][v][o];
      end
    end
  endtask

  task automatic run(input bit we, input int a, input logic [31:0] wd, input bit c,
                     input bit wt, input bit lk, input string rq);
    int er, ew;
    logic [31:0] ed;
    bit fill;
    model(we, a, wd, c, wt, lk, er, ew, ed, fill);
    @(negedge clk);
    rd_beats = 0; wr_beats = 0; rd_addr_q.delete();
    req_valid = 1; req_we = we; req_addr = a; req_wdata = wd;
    req_c = c; req_wt = wt; req_lk = lk;
    do @(negedge clk); while (!done);
    req_valid = 0;
    chk(rd_beats == er, rq, $sformatf("read beats @%0h", a), rd_beats, er);
    chk(wr_beats == ew, rq, $sformatf("write beats @%0h", a), wr_beats, ew);
    if (!we) chk(rdata == ed, rq, $sformatf("rdata @%0h", a), rdata, ed);
    if (fill && rd_addr_q.size() == NW)
      for (int k = 0; k < NW; k++)
        chk(rd_addr_q[k] == (a & ~32'hF) + 4 * k, "R3", "fill order", rd_addr_q[k],
            (a & ~32'hF) + 4 * k);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < MEMW; i++) begin
      bmem[i] = 32'hC0DE_0000 + i; mmem[i] = 32'hC0DE_0000 + i;
    end
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < 4; w++) begin
        m_v[s][w] = 0; m_d[s][w] = 0; m_l[s][w] = 0; m_tag[s][w] = 0; m_ts[s][w] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !mem_req, "R1", "idle after reset", {done, mem_req}, 0);

    run(0, adr(0,0,2), 0, 1, 0, 0, "R1");            // first read misses
    run(0, adr(0,0,2), 0, 1, 0, 0, "R2");            // hit
    run(0, adr(0,0,3), 0, 1, 0, 0, "R2");
    run(1, adr(0,0,1), 32'h1111_AAAA, 1, 0, 0, "R5"); // write-back hit
    run(0, adr(0,0,1), 0, 1, 0, 0, "R2");
    run(1, adr(0,0,0), 32'h2222_BBBB, 1, 1, 0, "R6"); // write-through hit
    run(0, adr(0,0,0), 0, 1, 0, 0, "R6");
    run(1, adr(1,0,2), 32'h3333_CCCC, 1, 0, 0, "R4"); // write miss
    run(0, adr(1,0,2), 0, 1, 0, 0, "R4");            // then read misses
    run(0, adr(0,0,1), 0, 0, 0, 0, "R10");           // bypass sees stale memory
    run(1, adr(9,2,3), 32'h4444_DDDD, 0, 0, 0, "R10");
    run(0, adr(0,0,1), 0, 1, 0, 0, "R10");           // cached copy untouched
    // recency order in set 1
    for (int t = 0; t < 4; t++) run(0, adr(t,1,0), 0, 1, 0, 0, "R7");
    run(0, adr(0,1,1), 0, 1, 0, 0, "R7");
    run(0, adr(4,1,0), 0, 1, 0, 0, "R7");            // replaces tag 1
    run(0, adr(0,1,2), 0, 1, 0, 0, "R7");
    run(0, adr(1,1,0), 0, 1, 0, 0, "R7");
    // pinning in set 2
    run(0, adr(0,2,0), 0, 1, 0, 1, "R8");
    for (int t = 1; t < 8; t++) run(0, adr(t,2,1), 0, 1, 0, 0, "R8");
    run(0, adr(0,2,3), 0, 1, 0, 0, "R8");            // still resident
    // full pin in set 3
    for (int t = 0; t < 4; t++) run(0, adr(t,3,0), 0, 1, 0, 1, "R8");
    run(0, adr(4,3,2), 0, 1, 0, 0, "R9");
    run(0, adr(4,3,2), 0, 1, 0, 0, "R9");
    for (int t = 0; t < 4; t++) run(0, adr(t,3,1), 0, 1, 0, 0, "R9");
    // force the modified line in set 0 out
    for (int t = 2; t < 6; t++) run(0, adr(t,0,0), 0, 1, 0, 0, "R5");
    run(0, adr(0,0,1), 0, 0, 0, 0, "R5");            // memory now holds written data
    run(0, adr(0,0,1), 0, 1, 0, 0, "R5");
    @(negedge clk);
    begin
      int bad = 0;
      for (int i = 0; i < MEMW; i++) if (bmem[i] !== mmem[i]) bad++;
      chk(bad == 0, "R5", "memory image mismatches", bad, 0);
    end
    finish_run();
  end
endmodule